// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast event stream by a programmable 16-bit ratio and emits one pulse per division period to a downstream phase comparator. Each event is one cycle in which `in_en` is high, and stands for one cycle of the selected RF input. The divider is built from three parts. An optional divide-by-two stage comes first. It feeds a dual-modulus prescaler model that counts 17 or 16 events per output tick. The ticks then drive a 4-bit swallow counter and a 12-bit main counter. A direct band bypasses the prescaler and divides by the upper twelve divisor bits only.

The divisor and band code are sampled only when a period ends, or on the first active cycle after reset or standby. The period in progress is therefore never disturbed by new settings. While `standby` is high the divider halts and emits nothing. When standby is released, the divider starts a fresh period.

Top module: `pswd_divider`

## Requirements
- R1: `band_mode` 2'b01 and 2'b11 both select pulse-swallow division. Each period is exactly `divisor` events long, and the period length is the same for either code.
- R2: In pulse-swallow division, divisor bits [3:0] form the swallow count s and bits [15:4] form the main count m. The prescaler counts 17 events per tick while the swallow counter is nonzero and 16 events per tick after that, so a period is 16*m+s events. This holds over the full 528..65535 range, for s = 0 and for s = 15.
- R3: `band_mode` 2'b00 selects direct division by `divisor[15:4]` (range 16..4095). Bits [3:0] have no effect on the period.
- R4: `band_mode` 2'b10 selects a divide-by-two stage ahead of pulse-swallow division, so a period is 2*`divisor` events.
- R5: `div_pulse` is high for exactly one cycle. It rises in the cycle after the clock edge that takes in the last event of a period.
- R6: `divisor` and `band_mode` are sampled only at the edge that ends a period, or at the first load after reset or standby. A change during a period does not alter that period; it sets the length of the next period.
- R7: While `standby` is high, no events are counted and `div_pulse` stays low. The first clock edge with `standby` low loads the current settings and ignores `in_en`. A full new period then follows.
- R8: During reset and before the first load, `div_pulse` is low.
- R9: Cycles with `in_en` low do not advance the divider, whatever their position in a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_en | input | 1 | One RF input event in this cycle |
| divisor | input | 16 | Programmed division value |
| band_mode | input | 2 | Band code: 00 direct, 01/11 pulse swallow, 10 halve then swallow |
| standby | input | 1 | Halts division and suppresses output |
| div_pulse | output | 1 | One-cycle pulse per completed period |

## Verification
Any wrong internal count shows up at the ports as a wrong distance between two `div_pulse` edges. Examples are a swallow counter that under-runs, a prescaler modulus switched at the wrong time, or a half-rate phase left over from a previous band. The error is visible by the end of the period in which it occurred, at most one full period later, because every period is measured event by event against the ratio set by the requirements. A settings capture at the wrong time moves the length change onto the wrong period, so it is detected on the first pulse after the change.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
  localparam int DIV_W  = 16;
  localparam int SWL_W  = 4;
  localparam int MAIN_W = DIV_W - SWL_W;

  typedef enum logic [1:0] {
    BAND_DIRECT = 2'b00,
    BAND_SWL_A  = 2'b01,
    BAND_HALF   = 2'b10,
    BAND_SWL_B  = 2'b11
  } band_e;

  // upper field: main count in every band
  function automatic logic [MAIN_W-1:0] main_of(input logic [DIV_W-1:0] d);
    return d[DIV_W-1:SWL_W];
  endfunction

  // lower field: swallow count, unused in the direct band
  function automatic logic [SWL_W-1:0] swallow_of(input logic [DIV_W-1:0] d,
                                                  input logic [1:0] band);
    return (band == BAND_DIRECT) ? '0 : d[SWL_W-1:0];
  endfunction
endpackage

// File: rtl/pswd_half_stage.sv
module pswd_half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_half,
  input  logic ev_in,
  output logic ev_out
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= 1'b0;
    else if (clr)               phase <= 1'b0;
    else if (ev_in && en_half)  phase <= ~phase;
  end

  assign ev_out = ev_in && (!en_half || phase);

  // halved stream never passes two consecutive events (R4)
  assert_half_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_half && ev_out) |=> (!ev_out || !en_half));
endmodule

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int BASE_MOD = 16,
  parameter int PW = $clog2(BASE_MOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bypass,
  input  logic use_high,
  input  logic ev_in,
  output logic tick
);
  localparam logic [PW-1:0] LAST_LO = PW'(BASE_MOD - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(BASE_MOD);

  logic [PW-1:0] cnt;
  logic [PW-1:0] last;

  assign last = use_high ? LAST_HI : LAST_LO;
  assign tick = ev_in && (bypass || (cnt == last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (ev_in && !bypass) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  // modulus counter stays within the high modulus (R2)
  assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_HI);
  // bypassed prescaler holds its phase at zero (R3)
  assert_bypass_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !clr) |=> ($stable(cnt) || !bypass));
endmodule

// File: rtl/pswd_counters.sv
module pswd_counters #(
  parameter int SW = 4,
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic [SW-1:0] swl_init,
  input  logic [MW-1:0] main_init,
  output logic          swl_nz,
  output logic          terminal
);
  localparam logic [MW-1:0] MAIN_ONE = MW'(1);

  logic [SW-1:0] swl;
  logic [MW-1:0] main_c;

  assign swl_nz   = (swl != '0);
  assign terminal = tick && (main_c == MAIN_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swl    <= '0;
      main_c <= '0;
    end else if (load || terminal) begin
      swl    <= swl_init;
      main_c <= main_init;
    end else if (tick) begin
      main_c <= main_c - 1'b1;
      if (swl_nz) swl <= swl - 1'b1;
    end
  end

  // idle cycles leave the counts untouched (R9)
  assert_main_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(main_c));
  assert_swl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(swl));
endmodule

// File: rtl/pswd_divider.sv
module pswd_divider
  import pswd_pkg::*;
#(
  parameter int BASE_MOD = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_en,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       band_mode,
  input  logic             standby,
  output logic             div_pulse
);
  logic       armed;
  logic [1:0] cfg_band;
  logic       run, arm_load, reload;
  logic       ev_gated, ev_half, pre_tick, swl_nz, terminal;

  assign run      = armed && !standby;
  assign arm_load = !armed && !standby;
  assign ev_gated = in_en && run;
  assign reload   = arm_load || terminal;

  pswd_half_stage u_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (arm_load),
    .en_half (cfg_band == BAND_HALF),
    .ev_in   (ev_gated),
    .ev_out  (ev_half)
  );

  pswd_prescaler #(.BASE_MOD(BASE_MOD)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (arm_load),
    .bypass   (cfg_band == BAND_DIRECT),
    .use_high (swl_nz),
    .ev_in    (ev_half),
    .tick     (pre_tick)
  );

  pswd_counters #(.SW(SWL_W), .MW(MAIN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (arm_load),
    .tick      (pre_tick),
    .swl_init  (swallow_of(divisor, band_mode)),
    .main_init (main_of(divisor)),
    .swl_nz    (swl_nz),
    .terminal  (terminal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cfg_band  <= BAND_SWL_A;
      div_pulse <= 1'b0;
    end else begin
      if (standby)       armed <= 1'b0;
      else if (arm_load) armed <= 1'b1;
      if (reload) cfg_band <= band_mode;
      div_pulse <= terminal;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !div_pulse);
  assert_unarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !div_pulse);
  assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(cfg_band));
endmodule

// File: tb/pswd_divider_bench.sv
`timescale 1ns/1ps
module pswd_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b0;
  logic [15:0] divisor = 16'h0210;
  logic [1:0]  band_mode = 2'b01;
  logic        standby = 1'b0;
  logic        div_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int ev_cnt = 0;
  bit prev_pulse = 1'b0;
  string cur_req = "R8";
  int exp_q[$];

  always #2 clk = ~clk;

  pswd_divider u_pswd_divider (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .divisor(divisor),
    .band_mode(band_mode), .standby(standby), .div_pulse(div_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: measure events between pulses
  always @(negedge clk) begin
    if (!rst_n || standby) begin
      ev_cnt = 0;
      prev_pulse = 1'b0;
    end else begin
      if (div_pulse) begin
        pulses++;
        check(!prev_pulse, "R5", 1, 0);
        if (exp_q.size() == 0) check(1'b0, cur_req, ev_cnt, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(ev_cnt == e, cur_req, ev_cnt, e);
        end
        ev_cnt = 0;
      end
      prev_pulse = div_pulse;
      if (in_en) ev_cnt++;
    end
  end

  task automatic step(input logic e);
    in_en = e;
    @(posedge clk); #1;
  endtask

  // one period of n events; settings change before event chg
  task automatic period(input int n, input int chg, input logic [15:0] nd,
                        input logic [1:0] nm, input bit gaps);
    exp_q.push_back(n);
    for (int i = 0; i < n; i++) begin
      if (i == chg) begin divisor = nd; band_mode = nm; end
      if (gaps && (i % 7 == 3)) step(1'b0);
      step(1'b1);
    end
    step(1'b0);
    step(1'b0);
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R8", div_pulse, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;              // first load cycle, no event
    repeat (4) step(1'b0);
    check(pulses == 0, "R8", pulses, 0);

    cur_req = "R1"; period(528,   -1, 16'h0210, 2'b01, 0);
    cur_req = "R6"; period(528,  100, 16'h021F, 2'b11, 0);
    cur_req = "R2"; period(543,  200, 16'h0A3F, 2'b00, 0);
    cur_req = "R3"; period(163,   50, 16'h0A30, 2'b00, 0);
    cur_req = "R3"; period(163,   50, 16'h0258, 2'b10, 0);
    cur_req = "R4"; period(1200, 500, 16'h0100, 2'b00, 1);
    cur_req = "R3"; period(16,     5, 16'hFFF0, 2'b00, 0);
    cur_req = "R3"; period(4095, 1000, 16'hFFFF, 2'b01, 0);
    cur_req = "R2"; period(65535, 100, 16'h0258, 2'b10, 0);
    cur_req = "R9"; period(1200, 300, 16'h0210, 2'b01, 1);

    // R7: standby mid-period, events ignored, fresh period afterwards
    cur_req = "R7";
    for (int i = 0; i < 100; i++) step(1'b1);
    standby = 1'b1;
    snap = pulses;
    for (int i = 0; i < 600; i++) step(1'b1);
    step(1'b0);
    check(pulses == snap, "R7", pulses, snap);
    divisor = 16'h0300; band_mode = 2'b01;
    standby = 1'b0;
    step(1'b0);                       // load cycle
    period(768, -1, 16'h0300, 2'b01, 0);

    repeat (4) step(1'b0);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule